// File: doc/BRIEF.md
# Watchdog Timer with Power-State-Aware Outcome

This block is a watchdog for a processor subsystem. A slow low-power tick, given as a single-cycle enable in the system clock domain, advances an up-counter. If software does not service the counter in time, the counter reaches a terminal count and the block raises a timeout. A 5-bit code sets the terminal count: the period is 32 ticks times 2 to the power of the code. With a 32 kHz tick this gives 1 ms at code 0. Codes past the top setting act as the top setting.

There are two ways to enable the watchdog. A configuration input forces it on, and while that input is high software can neither turn the watchdog off nor lose it to a device reset. When the configuration input is low, a software ON bit alone enables the watchdog, and a device reset clears that bit.

The outcome of a timeout depends on the power state. While the core is awake, the block pulses a device reset request. While the core is in Sleep or Idle, it pulses a non-maskable wake request instead. A debug mode input freezes the count.

The counter restarts from zero on any of these:
- a device reset
- a service strobe
- a debug clear command
- an interrupt wake from a low-power state

Top module: `wdog_timer`

## Requirements
- R1: After a clear, a timeout occurs on exactly the 32*2^N-th slow tick, where N is the 5-bit code `ps_code` read as an unsigned number. The counter then restarts from zero, so further timeouts follow every 32*2^N ticks.
- R2: Any code above MAX_CODE (20 by default) gives the same period as MAX_CODE.
- R3: The counter advances only in cycles where `slow_tick` is 1.
- R4: A timeout while `sleep_mode` and `idle_mode` are both 0 drives `rst_req` to 1 for exactly one cycle, one cycle after the timing tick, with `nmi_req` left at 0.
- R5: A timeout while `sleep_mode` or `idle_mode` is 1 drives `nmi_req` to 1 for exactly one cycle, with `rst_req` left at 0.
- R6: `timeout_evt` pulses for one cycle with every timeout, whatever the power state.
- R7: While `cfg_force_en` is 1, `wdt_on` reads 1. Neither a software write of 0 nor `dev_rst` disables the watchdog in this state.
- R8: While `cfg_force_en` is 0, the software ON bit alone enables the watchdog. A cycle with `sw_on_wr`=1 loads `sw_on_val` into the ON bit, and `dev_rst` clears it.
- R9: The counter restarts from zero on `dev_rst`, `svc_clr`, `dbg_clr`, or `irq_wake` while Sleep or Idle is active. Entering Sleep or Idle does not clear the counter.
- R10: While `dbg_mode` is 1 the count holds its value and no timeout occurs. Counting resumes from that value when `dbg_mode` returns to 0.
- R11: While the watchdog is disabled, the count holds its value and no timeout, reset request or NMI request is produced.
- R12: While `rst_n` is low and just after its release, `rst_req`, `nmi_req`, `timeout_evt` are 0, the count is zero and the software ON bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| slow_tick | input | 1 | Single-cycle enable from the low-power oscillator |
| cfg_force_en | input | 1 | Configuration force-enable |
| ps_code | input | 5 | Postscaler code N |
| sw_on_wr | input | 1 | Write strobe for the software ON bit |
| sw_on_val | input | 1 | Value written to the software ON bit |
| svc_clr | input | 1 | Software service strobe, clears the count |
| dbg_mode | input | 1 | Debug mode, freezes the count |
| dbg_clr | input | 1 | Debug clear command |
| sleep_mode | input | 1 | Core is in Sleep |
| idle_mode | input | 1 | Core is in Idle |
| irq_wake | input | 1 | Interrupt wake from Sleep or Idle |
| dev_rst | input | 1 | Synchronous device reset pulse |
| wdt_on | output | 1 | Effective enable, as software reads ON |
| rst_req | output | 1 | Device reset request pulse |
| nmi_req | output | 1 | Non-maskable wake request pulse |
| timeout_evt | output | 1 | Timeout event pulse |

## Verification
The assertions take for granted that the period is at least 32 ticks and that a timeout cannot be followed by another within one cycle. This is why a second request pulse right after a first one counts as an error. They also assume that the power-state inputs are steady in the cycle of the timing tick.

The stimulus holds `ps_code`, `sleep_mode` and `idle_mode` steady from one clear to the next timeout. It raises the clear strobes only between ticks, and it asserts `irq_wake` only while Sleep or Idle is set. The bench uses a smaller MAX_CODE, so that saturation can be seen within a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    OUTC_NONE  = 2'd0,
    OUTC_RESET = 2'd1,
    OUTC_NMI   = 2'd2
  } wdt_outcome_e;

  function automatic int unsigned sat_code(input int unsigned code,
                                           input int unsigned max_code);
    return (code > max_code) ? max_code : code;
  endfunction

endpackage

// File: rtl/wdt_period_sel.sv
module wdt_period_sel #(
  parameter int CODE_W     = 5,
  parameter int BASE_SHIFT = 5,
  parameter int MAX_CODE   = 20,
  localparam int CNT_W     = BASE_SHIFT + MAX_CODE
) (
  input  logic [CODE_W-1:0] ps_code,
  output logic [CNT_W-1:0]  term_cnt
);
  import wdt_pkg::*;

  int unsigned eff_code;

  always_comb begin
    eff_code = sat_code(int'(ps_code), MAX_CODE);
  end

  // Terminal count is a run of ones: bit b set when b < BASE_SHIFT + code.
  for (genvar b = 0; b < CNT_W; b++) begin : g_term
    assign term_cnt[b] = (b < (BASE_SHIFT + int'(eff_code)));
  end

  always_comb begin
    // R2
    sat_term_chk : assert (term_cnt[CNT_W-1] == (int'(ps_code) >= MAX_CODE));
  end

endmodule

// File: rtl/wdt_enable_ctrl.sv
module wdt_enable_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_force_en,
  input  logic dev_rst,
  input  logic sw_on_wr,
  input  logic sw_on_val,
  output logic wdt_on
);

  logic sw_on_q;
  logic sw_on_d;

  always_comb begin
    sw_on_d = sw_on_q;
    if (dev_rst)       sw_on_d = 1'b0;
    else if (sw_on_wr) sw_on_d = sw_on_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_on_q <= 1'b0;
    else        sw_on_q <= sw_on_d;
  end

  assign wdt_on = cfg_force_en | sw_on_q;

  // R8
  sw_rst_off_chk : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dev_rst) && !cfg_force_en) |-> !wdt_on);

  // R8
  sw_write_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (sw_on_wr && !dev_rst && !cfg_force_en) |=> (cfg_force_en || (wdt_on == $past(sw_on_val))));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] term_cnt,
  output logic             hit,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign hit = run & ~clr & (cnt_q == term_cnt);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (hit) cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R9
  clr_zero_chk : assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R3
  idle_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt));

endmodule

// File: rtl/wdt_outcome.sv
module wdt_outcome (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic sleep_mode,
  input  logic idle_mode,
  output logic rst_req,
  output logic nmi_req,
  output logic timeout_evt
);
  import wdt_pkg::*;

  wdt_outcome_e sel;
  logic         rst_q, nmi_q, evt_q;

  always_comb begin
    if (!hit)                         sel = OUTC_NONE;
    else if (sleep_mode || idle_mode) sel = OUTC_NMI;
    else                              sel = OUTC_RESET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      rst_q <= (sel == OUTC_RESET);
      nmi_q <= (sel == OUTC_NMI);
      evt_q <= (sel != OUTC_NONE);
    end
  end

  assign rst_req     = rst_q;
  assign nmi_req     = nmi_q;
  assign timeout_evt = evt_q;

  // R4
  excl_req_chk : assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && nmi_req));

  // R4
  rst_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R5
  nmi_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  // R6
  evt_cover_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || nmi_req) |-> timeout_evt);

  // R5
  nmi_state_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (sleep_mode || idle_mode)) |=> nmi_req);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CODE_W     = 5,
  parameter int BASE_SHIFT = 5,
  parameter int MAX_CODE   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              cfg_force_en,
  input  logic [CODE_W-1:0] ps_code,
  input  logic              sw_on_wr,
  input  logic              sw_on_val,
  input  logic              svc_clr,
  input  logic              dbg_mode,
  input  logic              dbg_clr,
  input  logic              sleep_mode,
  input  logic              idle_mode,
  input  logic              irq_wake,
  input  logic              dev_rst,
  output logic              wdt_on,
  output logic              rst_req,
  output logic              nmi_req,
  output logic              timeout_evt
);

  localparam int CNT_W = BASE_SHIFT + MAX_CODE;

  logic [CNT_W-1:0] term_cnt;
  logic [CNT_W-1:0] cnt;
  logic             hit;
  logic             run;
  logic             clr;
  logic             low_pwr;

  assign low_pwr = sleep_mode | idle_mode;
  assign clr     = dev_rst | svc_clr | dbg_clr | (irq_wake & low_pwr);
  assign run     = wdt_on & slow_tick & ~dbg_mode;

  wdt_enable_ctrl u_en (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_force_en (cfg_force_en),
    .dev_rst      (dev_rst),
    .sw_on_wr     (sw_on_wr),
    .sw_on_val    (sw_on_val),
    .wdt_on       (wdt_on)
  );

  wdt_period_sel #(
    .CODE_W     (CODE_W),
    .BASE_SHIFT (BASE_SHIFT),
    .MAX_CODE   (MAX_CODE)
  ) u_psel (
    .ps_code  (ps_code),
    .term_cnt (term_cnt)
  );

  wdt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clr      (clr),
    .term_cnt (term_cnt),
    .hit      (hit),
    .cnt      (cnt)
  );

  wdt_outcome u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (hit),
    .sleep_mode  (sleep_mode),
    .idle_mode   (idle_mode),
    .rst_req     (rst_req),
    .nmi_req     (nmi_req),
    .timeout_evt (timeout_evt)
  );

  // R10
  dbg_freeze_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !clr) |=> $stable(cnt));

  // R11
  off_quiet_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_on && !clr) |=> ($stable(cnt) && !timeout_evt));

  // R7
  force_on_chk : assert property (@(posedge clk) disable iff (!rst_n)
    cfg_force_en |-> wdt_on);

  // R1
  term_bound_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && $stable(ps_code)) |-> (cnt == '0));

endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;

  localparam int BMAX = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       slow_tick, cfg_force_en, sw_on_wr, sw_on_val, svc_clr;
  logic       dbg_mode, dbg_clr, sleep_mode, idle_mode, irq_wake, dev_rst;
  logic [4:0] ps_code;
  logic       wdt_on, rst_req, nmi_req, timeout_evt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wdog_timer #(.MAX_CODE(BMAX)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .cfg_force_en(cfg_force_en),
    .ps_code(ps_code), .sw_on_wr(sw_on_wr), .sw_on_val(sw_on_val), .svc_clr(svc_clr),
    .dbg_mode(dbg_mode), .dbg_clr(dbg_clr), .sleep_mode(sleep_mode), .idle_mode(idle_mode),
    .irq_wake(irq_wake), .dev_rst(dev_rst), .wdt_on(wdt_on), .rst_req(rst_req),
    .nmi_req(nmi_req), .timeout_evt(timeout_evt)
  );

  // {code[4:0], sleep, idle, tick divider[2:0]}
  localparam logic [9:0] VEC [0:8] = '{
    {5'd0,  1'b0, 1'b0, 3'd1},
    {5'd1,  1'b0, 1'b0, 3'd1},
    {5'd2,  1'b0, 1'b0, 3'd2},
    {5'd1,  1'b1, 1'b0, 3'd1},
    {5'd0,  1'b0, 1'b1, 3'd2},
    {5'd3,  1'b1, 1'b1, 3'd3},
    {5'd4,  1'b0, 1'b0, 3'd1},
    {5'd31, 1'b0, 1'b0, 3'd1},
    {5'd9,  1'b0, 1'b1, 3'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_ev(input int d, input int maxc, output int n,
                          output bit r, output bit m, output bit t);
    n = 0; r = 0; m = 0; t = 0;
    for (int j = 1; j <= maxc; j++) begin
      slow_tick = ((j % d) == 0);
      @(posedge clk);
      @(negedge clk);
      if (rst_req || nmi_req || timeout_evt) begin
        n = j; r = rst_req; m = nmi_req; t = timeout_evt;
        break;
      end
    end
    slow_tick = 1'b0;
  endtask

  // kind: 0 service, 1 debug clear, 2 device reset, 3 interrupt wake
  task automatic do_clear(input int kind);
    case (kind)
      0: svc_clr  = 1'b1;
      1: dbg_clr  = 1'b1;
      2: dev_rst  = 1'b1;
      default: irq_wake = 1'b1;
    endcase
    @(posedge clk);
    @(negedge clk);
    svc_clr = 1'b0; dbg_clr = 1'b0; dev_rst = 1'b0; irq_wake = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int  n;
    bit  r, m, t;
    int  per, d, code;

    rst_n = 1'b0; slow_tick = 0; cfg_force_en = 0; sw_on_wr = 0; sw_on_val = 0;
    svc_clr = 0; dbg_mode = 0; dbg_clr = 0; sleep_mode = 0; idle_mode = 0;
    irq_wake = 0; dev_rst = 0; ps_code = '0;
    repeat (3) @(negedge clk);
    chk(!rst_req && !nmi_req && !timeout_evt, "R12 outputs in reset", int'(rst_req|nmi_req|timeout_evt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wdt_on == 1'b0, "R12 ON after reset", int'(wdt_on), 0);

    // R11: disabled, no events
    count_ev(1, 600, n, r, m, t);
    chk(n == 0, "R11 disabled quiet", n, 0);

    // R8: software enable
    sw_on_wr = 1; sw_on_val = 1;
    @(posedge clk); @(negedge clk);
    sw_on_wr = 0;
    chk(wdt_on == 1'b1, "R8 software ON", int'(wdt_on), 1);

    // Table: R1 R2 R3 R4 R5 R6
    for (int k = 0; k < 9; k++) begin
      code = int'(VEC[k][9:5]);
      d    = int'(VEC[k][2:0]);
      per  = (32 << ((code > BMAX) ? BMAX : code)) * d;
      ps_code = VEC[k][9:5]; sleep_mode = VEC[k][4]; idle_mode = VEC[k][3];
      do_clear(0);
      count_ev(d, 4000, n, r, m, t);
      chk(n == per, "R1 R2 R3 period", n, per);
      if (VEC[k][4] || VEC[k][3]) chk(m && !r, "R5 nmi in low power", int'(m), 1);
      else                        chk(r && !m, "R4 reset when awake", int'(r), 1);
      chk(t, "R6 timeout event", int'(t), 1);
      @(posedge clk); @(negedge clk);
      chk(!rst_req && !nmi_req, "R4 R5 single pulse", int'(rst_req|nmi_req), 0);
      sleep_mode = 0; idle_mode = 0;
    end

    // Repeating period: R1
    ps_code = 5'd0;
    do_clear(0);
    count_ev(1, 100, n, r, m, t);
    count_ev(1, 100, n, r, m, t);
    chk(n == 32, "R1 restart after timeout", n, 32);

    // R9 clears restart a full period
    for (int kind = 0; kind < 4; kind++) begin
      if (kind == 2) continue;
      do_clear(0);
      count_ev(1, 20, n, r, m, t);
      if (kind == 3) idle_mode = 1;
      do_clear(kind);
      count_ev(1, 100, n, r, m, t);
      chk(n == 32, "R9 clear restarts count", n, 32);
      idle_mode = 0;
    end

    // R9: entering sleep does not clear
    do_clear(0);
    count_ev(1, 20, n, r, m, t);
    sleep_mode = 1;
    count_ev(1, 100, n, r, m, t);
    chk(n == 12 && m, "R9 sleep entry keeps count", n, 12);
    sleep_mode = 0;

    // R10: debug freeze
    do_clear(0);
    count_ev(1, 10, n, r, m, t);
    dbg_mode = 1;
    count_ev(1, 100, n, r, m, t);
    chk(n == 0, "R10 no timeout in debug", n, 0);
    dbg_mode = 0;
    count_ev(1, 100, n, r, m, t);
    chk(n == 22, "R10 resume after debug", n, 22);

    // R8: software off, then device reset clears ON
    sw_on_wr = 1; sw_on_val = 0;
    @(posedge clk); @(negedge clk);
    sw_on_wr = 0;
    chk(wdt_on == 1'b0, "R8 software OFF", int'(wdt_on), 0);
    sw_on_wr = 1; sw_on_val = 1;
    @(posedge clk); @(negedge clk);
    sw_on_wr = 0;
    do_clear(2);
    chk(wdt_on == 1'b0, "R8 device reset clears ON", int'(wdt_on), 0);
    count_ev(1, 200, n, r, m, t);
    chk(n == 0, "R11 quiet after reset", n, 0);

    // R7: configuration force
    cfg_force_en = 1;
    @(posedge clk); @(negedge clk);
    chk(wdt_on == 1'b1, "R7 forced ON", int'(wdt_on), 1);
    sw_on_wr = 1; sw_on_val = 0;
    @(posedge clk); @(negedge clk);
    sw_on_wr = 0;
    chk(wdt_on == 1'b1, "R7 write 0 ignored", int'(wdt_on), 1);
    do_clear(2);
    chk(wdt_on == 1'b1, "R7 reset keeps ON", int'(wdt_on), 1);
    count_ev(1, 100, n, r, m, t);
    chk(n == 32 && r, "R7 R9 forced timeout after reset", n, 32);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule